// File: doc/BRIEF.md
# Serial NOR Flash Device Emulator

This block is a synthesizable stand-in for a small serial NOR flash, meant to sit on the far side of a chip's SPI flash controller so that boot, program and erase paths can be exercised without an external part. It behaves as an SPI mode-0 slave. The chip-select, serial clock and data-in pins are oversampled in the system clock domain. After chip select falls, the first byte is taken as an opcode. A 24-bit address, most significant byte first, and any data bytes follow.

The backing store is an on-chip byte array of `MEM_BYTES` entries. It is filled with 0xFF at reset, and device addresses map onto it modulo its size. The model honours the flash rules that a program can only clear bits and an erase can only set them. It gates program and erase with a write-enable latch and reports a write-in-progress flag. That flag stays set for a parameterised number of system clocks after the operation is committed, and most commands are refused while it is set. Signature reads return a parameterised density code.

Top module: `nor_emu`

## Requirements
- R1: After reset, `miso` is low and a status read (opcode 0x05) returns 0x00.
- R2: Data on `mosi` is sampled at rising `sck` and `miso` changes only after falling `sck`, both most significant bit first. The first byte after `csN` falls is the opcode and the next three bytes are the address, high byte first.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R4: Opcode 0x05 shifts out the status byte: bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are zero. The byte is refreshed and repeated for as long as `csN` stays low.
- R5: Opcode 0x03 followed by an address returns the byte at that address and then successive bytes. The address increments across 256-byte page boundaries.
- R6: Opcode 0x02 with the latch set ANDs each data byte into the array. Only the low 8 address bits advance, so data past the end of a 256-byte page wraps to the start of the same page.
- R7: Opcode 0xD8 with the latch set and a full 3-byte address sets every byte of the 64 KiB sector holding that address to 0xFF once `csN` rises. The sector is clipped to the array.
- R8: Program and erase opcodes issued while the latch is clear leave the array unchanged and do not raise write-in-progress.
- R9: Write-in-progress rises when `csN` rises after an accepted program (at least one data byte) or erase. It stays set for `PROG_BUSY` clocks after a program, or for the longer of that count and the erase walk after an erase. When it falls, the latch clears.
- R10: While write-in-progress is set, every opcode except 0x05 is ignored and the rest of that transaction shifts out 0x00.
- R11: Opcode 0xAB shifts out three don't-care bytes, then `SIG_CODE` repeated while `csN` stays low. The default code is 0x13 (8 Mbit), and larger densities rise by one per doubling.
- R12: The array holds 0xFF after reset, and addresses at or above `MEM_BYTES` alias modulo the array size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are oversampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, driven low while deselected |

## Verification
The hardest situation to reach from the pins is a command arriving while write-in-progress is still set. The stimulus has to finish a program, deselect, and start a new transaction within `PROG_BUSY` clocks. The bench does this by issuing a data read straight after a program. It expects all-zero output, and afterwards it confirms that the programmed value is intact. Page wrap is reached by programming four bytes starting two below a page end, then reading across the boundary to show that the next page stayed erased. Aliasing is reached by programming an address beyond the array.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'hD8;
  localparam logic [7:0] OP_SIG   = 8'hAB;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RDSR,
    CMD_READ,
    CMD_PROG,
    CMD_ERASE,
    CMD_SIG
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        progWr;   // AND one byte into the array
    logic        eraseGo;  // start the sector walk
    logic [23:0] addr;     // array address for read, program or erase
    logic [7:0]  data;     // byte to program
  } strobe_t;

endpackage

// File: rtl/nor_emu_datapath.sv
module nor_emu_datapath
  import nor_emu_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int SECTOR_BYTES = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  output logic [7:0] rdByte
);

  localparam int AW   = $clog2(MEM_BYTES);
  localparam int SPAN = (SECTOR_BYTES < MEM_BYTES) ? SECTOR_BYTES : MEM_BYTES;
  localparam int CW   = $clog2(SPAN) + 1;
  localparam logic [23:0] SECT_MASK = ~(24'(SECTOR_BYTES - 1));

  logic [7:0]    mem [MEM_BYTES];
  logic          eraseOn;
  logic [CW-1:0] eraseCnt;
  logic [AW-1:0] eraseBase;
  logic [AW-1:0] accIdx;
  logic [23:0]   sectorBase;

  assign accIdx     = strb.addr[AW-1:0];
  assign sectorBase = strb.addr & SECT_MASK;
  assign rdByte     = mem[accIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      eraseOn   <= 1'b0;
      eraseCnt  <= '0;
      eraseBase <= '0;
    end else begin
      if (strb.eraseGo) begin
        eraseOn   <= 1'b1;
        eraseCnt  <= '0;
        eraseBase <= sectorBase[AW-1:0];
      end else if (eraseOn) begin
        mem[eraseBase + eraseCnt[AW-1:0]] <= 8'hFF;
        eraseCnt <= eraseCnt + 1'b1;
        if (eraseCnt == CW'(SPAN - 1)) eraseOn <= 1'b0;
      end
      if (strb.progWr) mem[accIdx] <= mem[accIdx] & strb.data;
    end
  end

endmodule

// File: rtl/nor_emu_ctrl.sv
module nor_emu_ctrl
  import nor_emu_pkg::*;
#(
  parameter int         PROG_BUSY  = 200,
  parameter int         ERASE_BUSY = 512,
  parameter logic [7:0] SIG_CODE   = 8'h13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       mosi,
  input  logic [7:0] rdByte,
  output logic       miso,
  output strobe_t    strb,
  output logic       wip,
  output logic       wel,
  output logic       selIdle
);

  localparam int BUSY_MAX = (PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY;
  localparam int BW       = $clog2(BUSY_MAX + 1);

  logic          sckQ, sckPrev, csQ, csPrev, mosiQ;
  logic [2:0]    bitCnt, byteCnt;
  logic [6:0]    shiftIn;
  logic [23:0]   addrReg;
  cmd_e          cmd, newCmd;
  logic          wrote;
  logic [BW-1:0] busyCnt;
  logic [7:0]    txReg, txLoad, inByte, statusByte;
  logic          misoR, welR;
  logic          sckRise, sckFall, csRise, byteDone;
  logic [23:0]   fullAddr;

  assign sckRise    = sckQ & ~sckPrev & ~csQ;
  assign sckFall    = ~sckQ & sckPrev & ~csQ;
  assign csRise     = csQ & ~csPrev;
  assign byteDone   = sckRise && (bitCnt == 3'd7);
  assign inByte     = {shiftIn, mosiQ};
  assign fullAddr   = {addrReg[15:0], inByte};
  assign wip        = (busyCnt != '0);
  assign wel        = welR;
  assign miso       = misoR;
  assign selIdle    = csQ;
  assign statusByte = {6'b0, welR, wip};

  always_comb begin
    unique case (inByte)
      OP_RDSR:  newCmd = CMD_RDSR;
      OP_READ:  newCmd = wip ? CMD_NONE : CMD_READ;
      OP_PROG:  newCmd = (!wip && welR) ? CMD_PROG : CMD_NONE;
      OP_ERASE: newCmd = (!wip && welR) ? CMD_ERASE : CMD_NONE;
      OP_SIG:   newCmd = wip ? CMD_NONE : CMD_SIG;
      default:  newCmd = CMD_NONE;
    endcase
  end

  always_comb begin
    txLoad = 8'h00;
    if (byteCnt == 3'd0) begin
      if (newCmd == CMD_RDSR) txLoad = statusByte;
    end else begin
      case (cmd)
        CMD_RDSR: txLoad = statusByte;
        CMD_READ: if (byteCnt >= 3'd3) txLoad = rdByte;
        CMD_SIG:  if (byteCnt >= 3'd3) txLoad = SIG_CODE;
        default:  txLoad = 8'h00;
      endcase
    end
  end

  always_comb begin
    strb.progWr  = byteDone && (cmd == CMD_PROG) && (byteCnt == 3'd4);
    strb.eraseGo = csRise && (cmd == CMD_ERASE) && (byteCnt == 3'd4);
    strb.addr    = (byteCnt == 3'd3) ? fullAddr : addrReg;
    strb.data    = inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      sckPrev <= 1'b0;
      csQ     <= 1'b1;
      csPrev  <= 1'b1;
      mosiQ   <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      shiftIn <= '0;
      addrReg <= '0;
      cmd     <= CMD_NONE;
      wrote   <= 1'b0;
      busyCnt <= '0;
      txReg   <= '0;
      misoR   <= 1'b0;
      welR    <= 1'b0;
    end else begin
      sckQ    <= sck;
      sckPrev <= sckQ;
      csQ     <= csN;
      csPrev  <= csQ;
      mosiQ   <= mosi;

      if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == BW'(1)) welR <= 1'b0;
      end

      if (csQ) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        txReg   <= '0;
        misoR   <= 1'b0;
      end else begin
        if (sckRise) begin
          shiftIn <= inByte[6:0];
          bitCnt  <= bitCnt + 1'b1;
        end
        if (byteDone) begin
          txReg <= txLoad;
          if (byteCnt != 3'd4) byteCnt <= byteCnt + 1'b1;
          if (byteCnt == 3'd0) begin
            cmd   <= newCmd;
            wrote <= 1'b0;
            if (!wip && inByte == OP_WREN) welR <= 1'b1;
            if (!wip && inByte == OP_WRDI) welR <= 1'b0;
          end else if (byteCnt <= 3'd3) begin
            addrReg <= (cmd == CMD_READ && byteCnt == 3'd3) ? fullAddr + 24'd1 : fullAddr;
          end else begin
            if (cmd == CMD_READ) addrReg <= addrReg + 24'd1;
            if (cmd == CMD_PROG) begin
              addrReg[7:0] <= addrReg[7:0] + 8'd1;
              wrote        <= 1'b1;
            end
          end
        end else if (sckFall) begin
          misoR <= txReg[7];
          txReg <= {txReg[6:0], 1'b0};
        end
      end

      if (csRise) begin
        if (cmd == CMD_PROG && wrote) busyCnt <= BW'(PROG_BUSY);
        if (strb.eraseGo) busyCnt <= BW'(ERASE_BUSY);
        cmd <= CMD_NONE;
      end
    end
  end

endmodule

// File: rtl/nor_emu.sv
module nor_emu
  import nor_emu_pkg::*;
#(
  parameter int         MEM_BYTES    = 512,
  parameter int         SECTOR_BYTES = 65536,
  parameter int         PROG_BUSY    = 200,
  parameter logic [7:0] SIG_CODE     = 8'h13
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic mosi,
  output logic miso
);

  localparam int SPAN       = (SECTOR_BYTES < MEM_BYTES) ? SECTOR_BYTES : MEM_BYTES;
  localparam int ERASE_BUSY = (PROG_BUSY > SPAN) ? PROG_BUSY : SPAN;

  strobe_t    strb;
  logic [7:0] rdByte;
  logic       wip, wel, selIdle;

  nor_emu_ctrl #(
    .PROG_BUSY (PROG_BUSY),
    .ERASE_BUSY(ERASE_BUSY),
    .SIG_CODE  (SIG_CODE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sck    (sck),
    .csN    (csN),
    .mosi   (mosi),
    .rdByte (rdByte),
    .miso   (miso),
    .strb   (strb),
    .wip    (wip),
    .wel    (wel),
    .selIdle(selIdle)
  );

  nor_emu_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdByte(rdByte)
  );

endmodule

// File: rtl/nor_emu_checker.sv
module nor_emu_checker (
  input logic clk,
  input logic rstN,
  input logic wip,
  input logic wel,
  input logic selIdle,
  input logic progWr,
  input logic eraseGo
);

  assert_prog_needs_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    progWr |-> wel);

  assert_erase_needs_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> wel);

  assert_latch_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  assert_busy_starts_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(selIdle));

  assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !progWr);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progWr, eraseGo}));

  assert_erase_sets_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |=> wip);

endmodule

bind nor_emu nor_emu_checker u_check (
  .clk    (clk),
  .rstN   (rstN),
  .wip    (wip),
  .wel    (wel),
  .selIdle(selIdle),
  .progWr (strb.progWr),
  .eraseGo(strb.eraseGo)
);

// File: tb/tb_nor_emu.sv
module tb_nor_emu;

  logic clk = 1'b0;
  logic rstN, sck, csN, mosi, miso;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  nor_emu dut (
    .clk (clk),
    .rstN(rstN),
    .sck (sck),
    .csN (csN),
    .mosi(mosi),
    .miso(miso)
  );

  // {write address, read address, data programmed, expected read}
  localparam logic [63:0] VEC [4] = '{
    {24'h000010, 24'h000010, 8'hA5, 8'hA5},
    {24'h000010, 24'h000010, 8'h3C, 8'h24},
    {24'h000020, 24'h000020, 8'h00, 8'h00},
    {24'h000280, 24'h000080, 8'h5A, 8'h5A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rxb[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic selOn();
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic selOff();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendHdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    xfer(op, d);
    xfer(a[23:16], d);
    xfer(a[15:8], d);
    xfer(a[7:0], d);
  endtask

  task automatic oneOp(input logic [7:0] op);
    logic [7:0] d;
    selOn();
    xfer(op, d);
    selOff();
  endtask

  task automatic getStatus(output logic [7:0] s);
    logic [7:0] d;
    selOn();
    xfer(8'h05, d);
    xfer(8'h00, s);
    selOff();
  endtask

  task automatic readAt(input logic [23:0] a, output logic [7:0] d);
    selOn();
    sendHdr(8'h03, a);
    xfer(8'h00, d);
    selOff();
  endtask

  task automatic progAt(input logic [23:0] a, input logic [7:0] v);
    logic [7:0] d;
    selOn();
    sendHdr(8'h02, a);
    xfer(v, d);
    selOff();
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      getStatus(s);
      if (!s[0]) break;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, d2;
    rstN = 1'b0; sck = 1'b0; csN = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 miso after reset", {7'b0, miso}, 8'h00);
    getStatus(s);
    check("R1 status after reset", s, 8'h00);
    readAt(24'h000040, d);
    check("R12 erased at reset", d, 8'hFF);

    oneOp(8'h06);
    selOn(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, d2); selOff();
    check("R3 latch set", s, 8'h02);
    check("R4 status repeats", d2, 8'h02);
    oneOp(8'h04);
    getStatus(s);
    check("R3 latch cleared", s, 8'h00);

    progAt(24'h000030, 8'h00);
    getStatus(s);
    check("R8 no busy without latch", s, 8'h00);
    readAt(24'h000030, d);
    check("R8 program ignored", d, 8'hFF);

    for (int i = 0; i < 4; i++) begin
      oneOp(8'h06);
      progAt(VEC[i][63:40], VEC[i][15:8]);
      getStatus(s);
      check("R9 busy after program", s, 8'h03);
      waitIdle();
      getStatus(s);
      check("R9 latch dropped", s, 8'h00);
      readAt(VEC[i][39:16], d);
      check("R6 R12 program result", d, VEC[i][7:0]);
    end

    oneOp(8'h06);
    progAt(24'h000050, 8'h0F);
    readAt(24'h000050, d);
    check("R10 read refused while busy", d, 8'h00);
    waitIdle();
    readAt(24'h000050, d);
    check("R10 data intact after busy", d, 8'h0F);

    oneOp(8'h06);
    selOn();
    sendHdr(8'h02, 24'h0000FE);
    xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); xfer(8'h44, d);
    selOff();
    waitIdle();
    selOn();
    sendHdr(8'h03, 24'h0000FE);
    xfer(8'h00, d); check("R2 R5 seq byte 0", d, 8'h11);
    xfer(8'h00, d); check("R5 seq byte 1", d, 8'h22);
    xfer(8'h00, d); check("R6 next page untouched", d, 8'hFF);
    xfer(8'h00, d); check("R5 seq byte 3", d, 8'hFF);
    selOff();
    selOn();
    sendHdr(8'h03, 24'h000000);
    xfer(8'h00, d); check("R6 wrap byte 0", d, 8'h33);
    xfer(8'h00, d); check("R6 wrap byte 1", d, 8'h44);
    selOff();

    selOn();
    sendHdr(8'hAB, 24'h000000);
    xfer(8'h00, d); check("R11 signature", d, 8'h13);
    xfer(8'h00, d); check("R11 signature repeat", d, 8'h13);
    selOff();

    selOn(); sendHdr(8'hD8, 24'h000000); selOff();
    getStatus(s);
    check("R8 erase without latch not busy", s, 8'h00);
    readAt(24'h000010, d);
    check("R8 erase ignored", d, 8'h24);

    oneOp(8'h06);
    selOn(); sendHdr(8'hD8, 24'h000000); selOff();
    getStatus(s);
    check("R9 busy after erase", s, 8'h03);
    waitIdle();
    getStatus(s);
    check("R9 latch dropped after erase", s, 8'h00);
    readAt(24'h000010, d);
    check("R7 erased 0x10", d, 8'hFF);
    readAt(24'h000080, d);
    check("R7 erased 0x80", d, 8'hFF);
    readAt(24'h0000FE, d);
    check("R7 erased 0xFE", d, 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule